// File: doc/BRIEF.md
# UART Character Frame Codec

This block turns one data word into the bit pattern of an asynchronous serial character and, in the same pass, examines that pattern the way a receiver would. The transmit side and the receive side each take their own line-control byte. The transmit byte sets the word length, the parity mode and the stop-bit count used to build the frame. The receive byte sets what the checker expects to see. When the two bytes differ, the disagreement shows up as a parity or framing error in the status word.

A caller presents a data word and both control bytes with a one-cycle strobe. One clock later the block presents four things together with a one-cycle valid pulse: the packed frame with bit 0 sent first, the frame length in bits, the decoded data, and two error flags. Timing of bits on a wire and baud-rate generation are not part of this block.

Line-control byte fields (the same layout on both sides): bits [1:0] select the word length, bit 2 adds a second stop bit, bit 3 enables parity, bit 4 selects even parity (0 selects odd), and bit 5 selects stick parity. Bits [7:6] have no effect on framing or checking.

Top module: `uart_frame_codec`

## Requirements
- R1: The word length is the control field [1:0] plus 5, giving 5 to 8 bits. Data bits occupy frame bits 0 upward. Transmit data bits at or above the word length are cleared before framing, and transmit control bits [7:6] have no effect.
- R2: When transmit bit 3 is set and bit 5 is clear, a parity bit sits at the frame position equal to the word length. Its value is the XOR of the data bits when bit 4 is 1 (even), and the inverse of that XOR when bit 4 is 0 (odd).
- R3: When transmit bits 3 and 5 are both set, the parity bit is 1 whatever the data. When bit 3 is clear, bit 5 has no effect.
- R4: A stop bit of 1 follows the last data or parity bit. A second 1 follows when transmit bit 2 is set. Every frame bit at or above the frame length is 0. The frame length equals word length + parity + 1 + bit 2.
- R5: status[7:0] holds the frame bits below the receive word length, and zeros above it.
- R6: If receive bit 3 is clear, status[16] is 0. If receive bits 3 and 5 are both set, status[16] is 1 when the frame bit at the receive word length is 0. Otherwise, let X be the XOR of the frame bits from 0 up to and including the receive word length: status[16] is X in even mode and the inverse of X in odd mode.
- R7: The first expected stop position is the receive word length, plus 1 when receive bit 3 is set. status[17] is 1 if the frame bit at that position is 0, or if receive bit 2 is set and the next bit is 0.
- R8: status[15:8] is the receive control byte, all eight bits, as presented with the strobe.
- R9: The outputs update on the first clock edge after the edge that captures in_valid, and out_valid is high for exactly that one cycle per strobe. Without a strobe, the outputs hold their values.
- R10: When transmit and receive control bits [5:0] are equal, both error flags are 0.
- R11: After reset, out_valid, frame, frame_len and status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures one character |
| tx_data | input | 8 | Data word to frame |
| tx_ctl | input | 8 | Transmit line-control byte |
| rx_ctl | input | 8 | Receive line-control byte |
| out_valid | output | 1 | One-cycle pulse with a new result |
| frame | output | 11 | Packed frame, bit 0 first on the line |
| frame_len | output | 4 | Number of valid frame bits |
| status | output | 18 | {framing err, parity err, rx control, data} |

## Verification
Every one of the 64 transmit settings is run with an equal receive setting. This exercises parity and stop placement for each word length and shows that the checker raises no false error. Directed mismatches each drive one error path alone: a wrong parity sense, a missing second stop bit, a longer receive word, and stick parity against a disabled receiver. Data with bits set above the word length, and control bytes with bits [7:6] set, separate real masking and ignoring from accidental pass-through. Back-to-back strobes with random data and settings, followed by an idle stretch, show the one-cycle pulse and that the outputs hold between strobes.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

   localparam int unsigned CTL_W  = 8;
   localparam int unsigned WSEL_W = 2;

   typedef struct packed {
      logic              stick;
      logic              even;
      logic              par_en;
      logic              stop2;
      logic [WSEL_W-1:0] wsel;
   } line_cfg_t;

   // Only bits [5:0] of a control byte carry meaning.
   function automatic line_cfg_t cfg_from_ctl(input logic [5:0] c);
      line_cfg_t r;
      r.wsel   = c[1:0];
      r.stop2  = c[2];
      r.par_en = c[3];
      r.even   = c[4];
      r.stick  = c[5];
      return r;
   endfunction

endpackage

// File: rtl/ufc_frame_builder.sv
module ufc_frame_builder
   import ufc_pkg::*;
#(
   parameter int unsigned MIN_WORD = 5,
   parameter int unsigned MAX_WORD = 8,
   parameter int unsigned FRAME_W  = 11,
   parameter int unsigned LEN_W    = 4
) (
   input  logic [MAX_WORD-1:0] data_i,
   input  line_cfg_t           cfg_i,
   output logic [FRAME_W-1:0]  frame_o,
   output logic [LEN_W-1:0]    len_o
);

   logic [LEN_W-1:0]    wlen;
   logic [LEN_W-1:0]    stop_pos;
   logic [MAX_WORD-1:0] kept;
   logic                par_src;
   logic                par_bit;

   assign wlen     = LEN_W'(MIN_WORD) + LEN_W'(cfg_i.wsel);
   assign stop_pos = wlen + LEN_W'(cfg_i.par_en);
   assign len_o    = stop_pos + LEN_W'(1) + LEN_W'(cfg_i.stop2);

   // Clear data bits beyond the selected word length.
   for (genvar g = 0; g < MAX_WORD; g++) begin : g_keep
      assign kept[g] = data_i[g] & (LEN_W'(g) < wlen);
   end

   assign par_src = ^kept;
   assign par_bit = cfg_i.stick | (cfg_i.even ? par_src : ~par_src);

   // Each frame position decides which field it belongs to.
   for (genvar g = 0; g < FRAME_W; g++) begin : g_bit
      logic in_data;
      logic at_par;
      logic at_stop1;
      logic at_stop2;
      if (g < MAX_WORD) begin : g_dat
         assign in_data = kept[g];
      end else begin : g_nodat
         assign in_data = 1'b0;
      end
      assign at_par   = cfg_i.par_en & (LEN_W'(g) == wlen);
      assign at_stop1 = (LEN_W'(g) == stop_pos);
      assign at_stop2 = cfg_i.stop2 & (LEN_W'(g) == stop_pos + LEN_W'(1));
      assign frame_o[g] = in_data | (at_par & par_bit) | at_stop1 | at_stop2;
   end

endmodule

// File: rtl/ufc_frame_checker.sv
module ufc_frame_checker
   import ufc_pkg::*;
#(
   parameter int unsigned MIN_WORD = 5,
   parameter int unsigned MAX_WORD = 8,
   parameter int unsigned FRAME_W  = 11,
   parameter int unsigned LEN_W    = 4
) (
   input  logic [FRAME_W-1:0]  frame_i,
   input  line_cfg_t           cfg_i,
   output logic [MAX_WORD-1:0] data_o,
   output logic                par_err_o,
   output logic                frm_err_o
);

   logic [LEN_W-1:0]   wlen;
   logic [LEN_W-1:0]   stop_pos;
   logic [FRAME_W-1:0] par_span;
   logic [FRAME_W-1:0] hit_par;
   logic [FRAME_W-1:0] hit_s1;
   logic [FRAME_W-1:0] hit_s2;
   logic               sum;
   logic               pbit;
   logic               s1;
   logic               s2;

   assign wlen     = LEN_W'(MIN_WORD) + LEN_W'(cfg_i.wsel);
   assign stop_pos = wlen + LEN_W'(cfg_i.par_en);

   for (genvar g = 0; g < MAX_WORD; g++) begin : g_dat
      assign data_o[g] = frame_i[g] & (LEN_W'(g) < wlen);
   end

   // Position decoders pick single bits without variable indexing.
   for (genvar g = 0; g < FRAME_W; g++) begin : g_pos
      assign par_span[g] = frame_i[g] & (LEN_W'(g) <= wlen);
      assign hit_par[g]  = frame_i[g] & (LEN_W'(g) == wlen);
      assign hit_s1[g]   = frame_i[g] & (LEN_W'(g) == stop_pos);
      assign hit_s2[g]   = frame_i[g] & (LEN_W'(g) == stop_pos + LEN_W'(1));
   end

   assign sum  = ^par_span;
   assign pbit = |hit_par;
   assign s1   = |hit_s1;
   assign s2   = |hit_s2;

   assign par_err_o = cfg_i.par_en & (cfg_i.stick ? ~pbit : (cfg_i.even ? sum : ~sum));
   assign frm_err_o = ~s1 | (cfg_i.stop2 & ~s2);

endmodule

// File: rtl/uart_frame_codec.sv
module uart_frame_codec
   import ufc_pkg::*;
#(
   parameter  int unsigned MIN_WORD = 5,
   localparam int unsigned MAX_WORD = MIN_WORD + (2 ** WSEL_W) - 1,
   localparam int unsigned FRAME_W  = MAX_WORD + 3,
   localparam int unsigned LEN_W    = $clog2(FRAME_W + 1),
   localparam int unsigned STAT_W   = MAX_WORD + CTL_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [MAX_WORD-1:0] tx_data,
   input  logic [CTL_W-1:0]    tx_ctl,
   input  logic [CTL_W-1:0]    rx_ctl,
   output logic                out_valid,
   output logic [FRAME_W-1:0]  frame,
   output logic [LEN_W-1:0]    frame_len,
   output logic [STAT_W-1:0]   status
);

   if (MIN_WORD < 1 || MAX_WORD > 30) begin : g_bad_word
      $error("uart_frame_codec: MIN_WORD out of supported range");
   end

   line_cfg_t           tx_cfg;
   line_cfg_t           rx_cfg;
   logic [FRAME_W-1:0]  frame_d;
   logic [LEN_W-1:0]    len_d;
   logic [MAX_WORD-1:0] data_d;
   logic                perr_d;
   logic                ferr_d;
   logic [1:0]          unused_tx_hi;

   assign unused_tx_hi = tx_ctl[CTL_W-1:6];
   assign tx_cfg = cfg_from_ctl(tx_ctl[5:0]);
   assign rx_cfg = cfg_from_ctl(rx_ctl[5:0]);

   ufc_frame_builder #(
      .MIN_WORD(MIN_WORD), .MAX_WORD(MAX_WORD), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
   ) u_build (
      .data_i (tx_data),
      .cfg_i  (tx_cfg),
      .frame_o(frame_d),
      .len_o  (len_d)
   );

   ufc_frame_checker #(
      .MIN_WORD(MIN_WORD), .MAX_WORD(MAX_WORD), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
   ) u_check (
      .frame_i  (frame_d),
      .cfg_i    (rx_cfg),
      .data_o   (data_d),
      .par_err_o(perr_d),
      .frm_err_o(ferr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         frame     <= '0;
         frame_len <= '0;
         status    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            frame     <= frame_d;
            frame_len <= len_d;
            status    <= {ferr_d, perr_d, rx_ctl, data_d};
         end
      end
   end

   // R9: result pulse only follows a strobe
   p_pulse_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   // R9: outputs hold without a strobe
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(frame) && $stable(status) && $stable(frame_len)));
   // R4: length lies between the shortest and longest frame
   p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (frame_len >= LEN_W'(MIN_WORD + 1) && frame_len <= LEN_W'(FRAME_W)));
   // R4: last frame bit is a 1 stop bit and nothing lies above it
   p_stop_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((frame >> (frame_len - LEN_W'(1))) == FRAME_W'(1)));
   // R8: receive control byte is carried into the status word
   p_ctl_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (status[MAX_WORD +: CTL_W] == $past(rx_ctl)));
   // R10: identical settings on both sides never raise an error
   p_clean_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && tx_ctl[5:0] == rx_ctl[5:0]) |=> (status[STAT_W-1 -: 2] == 2'b00));

endmodule

// File: tb/tb_uart_frame_codec.sv
`timescale 1ns/1ps
module tb_uart_frame_codec;

   localparam int FW = 11;
   localparam int LW = 4;
   localparam int SW = 18;

   typedef struct packed {
      logic [FW-1:0] frame;
      logic [LW-1:0] len;
      logic [SW-1:0] status;
      logic          same;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [7:0]    tx_data;
   logic [7:0]    tx_ctl;
   logic [7:0]    rx_ctl;
   logic          out_valid;
   logic [FW-1:0] frame;
   logic [LW-1:0] frame_len;
   logic [SW-1:0] status;

   int   n_checks = 0;
   int   n_err    = 0;
   int   n_sent   = 0;
   int   n_seen   = 0;
   bit   done     = 0;
   exp_t sb[$];
   exp_t last_exp;

   always #2 clk = ~clk;

   uart_frame_codec dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tx_data(tx_data),
      .tx_ctl(tx_ctl), .rx_ctl(rx_ctl), .out_valid(out_valid), .frame(frame),
      .frame_len(frame_len), .status(status)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [7:0] d, input logic [7:0] tc, input logic [7:0] rc);
      exp_t          r;
      logic [FW-1:0] f;
      logic [7:0]    dd;
      logic          p, x, pe, fe;
      int            n, m, pos, q;
      f = '0; dd = '0; p = 1'b0; x = 1'b0;
      n = int'(tc[1:0]) + 5;
      for (int i = 0; i < n; i++) begin
         f[i] = d[i];
         p ^= d[i];
      end
      pos = n;
      if (tc[3]) begin
         f[pos] = tc[5] ? 1'b1 : (tc[4] ? p : ~p);
         pos++;
      end
      f[pos] = 1'b1;
      pos++;
      if (tc[2]) begin
         f[pos] = 1'b1;
         pos++;
      end
      m = int'(rc[1:0]) + 5;
      for (int i = 0; i < m; i++) dd[i] = f[i];
      for (int i = 0; i <= m; i++) x ^= f[i];
      pe = 1'b0;
      q  = m;
      if (rc[3]) begin
         pe = rc[5] ? ~f[m] : (rc[4] ? x : ~x);
         q  = m + 1;
      end
      fe = ~f[q] | (rc[2] & ~f[q+1]);
      r.frame  = f;
      r.len    = LW'(pos);
      r.status = {fe, pe, rc, dd};
      r.same   = (tc[5:0] == rc[5:0]);
      return r;
   endfunction

   // Driver: call at a falling edge; strobe lasts one cycle.
   task automatic send(input logic [7:0] d, input logic [7:0] tc, input logic [7:0] rc);
      tx_data  = d;
      tx_ctl   = tc;
      rx_ctl   = rc;
      in_valid = 1'b1;
      last_exp = model(d, tc, rc);
      sb.push_back(last_exp);
      n_sent++;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int k);
      in_valid = 1'b0;
      repeat (k) @(negedge clk);
   endtask

   // Monitor: compare each result against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_seen++;
         if (sb.size() == 0) begin
            chk("R9 out_valid without pending strobe", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk("R1/R2/R3 frame bits", 32'(frame), 32'(e.frame));
            chk("R4 frame length", 32'(frame_len), 32'(e.len));
            chk("R5 decoded data", 32'(status[7:0]), 32'(e.status[7:0]));
            chk("R6 parity error", 32'(status[16]), 32'(e.status[16]));
            chk("R7 framing error", 32'(status[17]), 32'(e.status[17]));
            chk("R8 receive control copy", 32'(status[15:8]), 32'(e.status[15:8]));
            if (e.same) chk("R10 matched settings error-free", 32'(status[17:16]), 0);
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
   endtask

   initial begin
      #(4 * 50000);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: run did not finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rnd;
      rst_n = 1'b0; in_valid = 1'b0; tx_data = '0; tx_ctl = '0; rx_ctl = '0;
      repeat (3) @(negedge clk);
      chk("R11 reset out_valid", 32'(out_valid), 0);
      chk("R11 reset frame", 32'(frame), 0);
      chk("R11 reset frame_len", 32'(frame_len), 0);
      chk("R11 reset status", 32'(status), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Every transmit setting with a matching receiver (R1..R4, R10).
      for (int c = 0; c < 64; c++) send(8'(c * 37 + 11), 8'(c), 8'(c));

      // Directed corner cases.
      send(8'hFF, 8'h00, 8'h00);   // R1: bits above 5 cleared
      send(8'h3C, 8'hC3, 8'h03);   // R1: tx bits 7:6 ignored
      send(8'h3C, 8'h03, 8'hC3);   // R8: rx bits 7:6 copied
      send(8'h0F, 8'h0B, 8'h1B);   // R2/R6: odd sent, even expected
      send(8'h0E, 8'h1B, 8'h0B);   // R2/R6: even sent, odd expected
      send(8'h00, 8'h2B, 8'h2B);   // R3: stick bit is 1 with zero data
      send(8'h00, 8'h23, 8'h03);   // R3: stick without enable ignored
      send(8'h00, 8'h03, 8'h2B);   // R6: stick expected, stop bit seen as parity
      send(8'h55, 8'h03, 8'h07);   // R7: second stop missing
      send(8'h55, 8'h00, 8'h03);   // R5/R7: longer receive word
      send(8'hAA, 8'h0F, 8'h03);   // R7: parity bit read as stop

      // Random back-to-back traffic.
      for (int i = 0; i < 300; i++) begin
         logic [7:0] tc, rc;
         rnd = $urandom;
         tc  = rnd[15:8];
         rc  = rnd[24] ? tc : rnd[23:16];
         send(rnd[7:0], tc, rc);
      end

      idle(6);
      chk("R9 out_valid low when idle", 32'(out_valid), 0);
      chk("R9 frame held when idle", 32'(frame), 32'(last_exp.frame));
      chk("R9 status held when idle", 32'(status), 32'(last_exp.status));
      chk("R9 one pulse per strobe", 32'(n_seen), 32'(n_sent));
      chk("R9 scoreboard drained", 32'(sb.size()), 0);

      done = 1;
      summary();
      $finish;
   end

endmodule